// File: doc/BRIEF.md
# PHY-Side Link Interface Wake-Up Sequencer

This block sits on the physical-layer side of a PHY-to-link-layer interface. It brings that interface back into service after the link layer has held the interface in reset or powered it down. It watches the link power-status input. Only after that input has stayed low for a minimum number of reference-clock cycles does a return to high count as a wake-up. A wake-up turns the interface clock enable on and starts a fixed, timed handshake on the control and data lines. Each group of lines has its own output-enable, so that high impedance is visible.

The handshake has two variants, and the mode strap picks one of them once, at wake-up. With the strap high (shared-driver mode), the PHY drives the lines low for a single cycle and then releases them. With the strap low (separate-driver mode), it drives them low for the whole opening window. In both modes the Receive code and an all-ones data word follow in the eighth cycle. In separate-driver mode only the first cycle of that indication is driven. The sequence then hands off to Idle, raises a completion flag and begins to forward link requests.

Control-line codes: Idle = 2'b00, Status = 2'b01, Receive = 2'b10, Grant = 2'b11.

Top module: `phy_link_init_seq`

## Requirements
- R1: After reset, and until a qualified wake-up, sysClkEn, ctlOe, dOe, initDone and lreqValid are 0, and ctlOut and dOut are 0.
- R2: A wake-up is qualified only at a rising edge where lpsIn is sampled 1 and lpsIn had been sampled 0 on at least MIN_OFF_CYCLES consecutive edges before it. Power-on reset counts as no low time. A high sample that comes too early clears the low count and starts no sequence.
- R3: Call the qualifying edge E0, and call the interval after edge E0+k cycle k. sysClkEn is 1 from cycle 1 for as long as the sequence or the Idle handoff lasts. ctlOe and dOe are never 1 while sysClkEn is 0.
- R4: Shared-driver mode (mode strap sampled 1 at E0): in cycle 1, ctlOut=2'b00 and dOut=0 with both enables 1. In cycles 2 to 7, both enables are 0.
- R5: Separate-driver mode (mode strap sampled 0 at E0): in cycles 1 to 7, ctlOut=2'b00 and dOut=0 with both enables 1.
- R6: In cycles 8 to 7+RX_CYCLES, ctlOut=2'b10 (Receive) and dOut is all ones. In shared-driver mode both enables stay 1 throughout these cycles.
- R7: In separate-driver mode both enables are 1 only in cycle 8. They are 0 in the remaining Receive cycles.
- R8: From cycle 8+RX_CYCLES, while lpsIn stays high: ctlOut=2'b00 (Idle), dOut=0, both enables 1, and initDone=1.
- R9: The mode strap is sampled only at E0. Later changes of the strap do not alter the running sequence.
- R10: lreqValid is 1 after an edge only if, at that edge, lreqIn was sampled 1, initDone was already 1, and lpsIn had not been sampled 0 on any edge since the handoff. In every other case lreqIn has no effect.
- R11: When lpsIn is sampled 0 at edge E during a sequence or after the handoff, all outputs return to the R1 values from the interval after E+1. That sample is the first count of a new low period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lpsIn | input | 1 | Link power-status level from the link layer |
| isoIn | input | 1 | Mode strap: 1 = shared-driver, 0 = separate-driver |
| lreqIn | input | 1 | Serial request line from the link layer |
| sysClkEn | output | 1 | Enable for the interface clock output |
| ctlOut | output | 2 | Control-line code |
| ctlOe | output | 1 | Output-enable for the control lines |
| dOut | output | DATA_W | Data-line value |
| dOe | output | 1 | Output-enable for the data lines |
| initDone | output | 1 | Handshake complete, requests forwarded |
| lreqValid | output | 1 | Request bit accepted after the handoff |

## Verification
The assertions assume that lpsIn, isoIn and lreqIn are synchronous to clk and settle well away from its rising edge. They also assume the parameters keep the opening window shorter than the Receive start cycle. The stimulus changes every input only at the falling edge. It draws low periods both shorter and longer than the minimum off time, so that both rejected and qualified wake-ups occur. The mode strap and the request line are also toggled in the middle of a sequence, so that the cases where they must be ignored are covered.

// File: rtl/lis_pkg.sv
package lis_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE    = 2'b00,
    CTL_STATUS  = 2'b01,
    CTL_RECEIVE = 2'b10,
    CTL_GRANT   = 2'b11
  } ctlCode_e;

  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seqState_e;

  typedef enum logic {
    DATA_ZERO = 1'b0,
    DATA_ONES = 1'b1
  } dataPat_e;

  // strobes from control to datapath, registered by the datapath
  typedef struct packed {
    logic     clkOn;
    logic     ctlDrive;
    logic     dataDrive;
    ctlCode_e ctlCode;
    dataPat_e dataPat;
    logic     markDone;
    logic     acceptReq;
  } strobes_t;

endpackage

// File: rtl/lis_ctrl.sv
module lis_ctrl
  import lis_pkg::*;
#(
  parameter int MIN_OFF_CYCLES   = 6,
  parameter int LOW_DRIVE_CYCLES = 7,
  parameter int RX_START         = 8,
  parameter int RX_CYCLES        = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     lpsIn,
  input  logic     isoIn,
  output strobes_t strobes
);

  localparam int OFF_W   = $clog2(MIN_OFF_CYCLES + 1);
  localparam int LAST_RX = RX_START + RX_CYCLES - 1;
  localparam int CYC_W   = $clog2(LAST_RX + 1);

  localparam logic [OFF_W-1:0] OFF_LIMIT = OFF_W'(MIN_OFF_CYCLES);
  localparam logic [OFF_W-1:0] OFF_ONE   = OFF_W'(1);
  localparam logic [CYC_W-1:0] CYC_FIRST = CYC_W'(1);
  localparam logic [CYC_W-1:0] CYC_LOWND = CYC_W'(LOW_DRIVE_CYCLES);
  localparam logic [CYC_W-1:0] CYC_RX    = CYC_W'(RX_START);
  localparam logic [CYC_W-1:0] CYC_LAST  = CYC_W'(LAST_RX);

  seqState_e        state, stateNext;
  logic [OFF_W-1:0] offCnt, offCntNext;
  logic [CYC_W-1:0] cycCnt, cycCntNext;
  logic             isoHeld, isoHeldNext;
  logic             wakeOk;

  // R2: wake-up only after a full low period
  assign wakeOk = lpsIn && (offCnt == OFF_LIMIT);

  always_comb begin
    stateNext   = state;
    offCntNext  = offCnt;
    cycCntNext  = cycCnt;
    isoHeldNext = isoHeld;
    unique case (state)
      SEQ_OFF: begin
        if (wakeOk) begin
          stateNext   = SEQ_RUN;
          cycCntNext  = CYC_FIRST;
          isoHeldNext = isoIn;       // R9: mode taken once
          offCntNext  = '0;
        end else if (lpsIn) begin
          offCntNext  = '0;          // early return restarts the count
        end else if (offCnt != OFF_LIMIT) begin
          offCntNext  = offCnt + OFF_ONE;
        end
      end
      SEQ_RUN: begin
        if (!lpsIn) begin
          stateNext  = SEQ_OFF;      // R11
          offCntNext = OFF_ONE;
        end else if (cycCnt == CYC_LAST) begin
          stateNext  = SEQ_DONE;
        end else begin
          cycCntNext = cycCnt + CYC_FIRST;
        end
      end
      SEQ_DONE: begin
        if (!lpsIn) begin
          stateNext  = SEQ_OFF;
          offCntNext = OFF_ONE;
        end
      end
      default: begin
        stateNext  = SEQ_OFF;
        offCntNext = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEQ_OFF;
      offCnt  <= '0;
      cycCnt  <= '0;
      isoHeld <= 1'b0;
    end else begin
      state   <= stateNext;
      offCnt  <= offCntNext;
      cycCnt  <= cycCntNext;
      isoHeld <= isoHeldNext;
    end
  end

  // strobe decode for the cycle counted by cycCnt
  always_comb begin
    strobes = '0;
    unique case (state)
      SEQ_RUN: begin
        strobes.clkOn = 1'b1;
        if (cycCnt < CYC_RX) begin
          strobes.ctlCode = CTL_IDLE;
          strobes.dataPat = DATA_ZERO;
          if (isoHeld) begin
            strobes.ctlDrive  = (cycCnt == CYC_FIRST);   // R4
            strobes.dataDrive = (cycCnt == CYC_FIRST);
          end else begin
            strobes.ctlDrive  = (cycCnt <= CYC_LOWND);   // R5
            strobes.dataDrive = (cycCnt <= CYC_LOWND);
          end
        end else begin
          strobes.ctlCode = CTL_RECEIVE;                 // R6
          strobes.dataPat = DATA_ONES;
          if (isoHeld) begin
            strobes.ctlDrive  = 1'b1;
            strobes.dataDrive = 1'b1;
          end else begin
            strobes.ctlDrive  = (cycCnt == CYC_RX);      // R7
            strobes.dataDrive = (cycCnt == CYC_RX);
          end
        end
      end
      SEQ_DONE: begin
        strobes.clkOn     = 1'b1;                        // R8
        strobes.ctlDrive  = 1'b1;
        strobes.dataDrive = 1'b1;
        strobes.ctlCode   = CTL_IDLE;
        strobes.dataPat   = DATA_ZERO;
        strobes.markDone  = 1'b1;
        strobes.acceptReq = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/lis_datapath.sv
module lis_datapath
  import lis_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic              lreqIn,
  output logic              sysClkEn,
  output logic [1:0]        ctlOut,
  output logic              ctlOe,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe,
  output logic              initDone,
  output logic              lreqValid
);

  logic [DATA_W-1:0] dNext;

  // per-bit pattern expansion
  for (genvar i = 0; i < DATA_W; i++) begin : g_dbit
    assign dNext[i] = (strobes.dataPat == DATA_ONES);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysClkEn  <= 1'b0;
      ctlOut    <= 2'b00;
      ctlOe     <= 1'b0;
      dOut      <= '0;
      dOe       <= 1'b0;
      initDone  <= 1'b0;
      lreqValid <= 1'b0;
    end else begin
      sysClkEn  <= strobes.clkOn;
      ctlOut    <= strobes.ctlCode;
      ctlOe     <= strobes.ctlDrive;
      dOut      <= dNext;
      dOe       <= strobes.dataDrive;
      initDone  <= strobes.markDone;
      // R10: request forwarded only once done is already visible
      lreqValid <= strobes.acceptReq & initDone & lreqIn;
    end
  end

endmodule

// File: rtl/phy_link_init_seq.sv
module phy_link_init_seq
  import lis_pkg::*;
#(
  parameter int MIN_OFF_CYCLES   = 6,
  parameter int LOW_DRIVE_CYCLES = 7,
  parameter int RX_START         = 8,
  parameter int RX_CYCLES        = 2,
  parameter int DATA_W           = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lpsIn,
  input  logic              isoIn,
  input  logic              lreqIn,
  output logic              sysClkEn,
  output logic [1:0]        ctlOut,
  output logic              ctlOe,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe,
  output logic              initDone,
  output logic              lreqValid
);

  strobes_t strobes;

  lis_ctrl #(
    .MIN_OFF_CYCLES  (MIN_OFF_CYCLES),
    .LOW_DRIVE_CYCLES(LOW_DRIVE_CYCLES),
    .RX_START        (RX_START),
    .RX_CYCLES       (RX_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .lpsIn  (lpsIn),
    .isoIn  (isoIn),
    .strobes(strobes)
  );

  lis_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .lreqIn   (lreqIn),
    .sysClkEn (sysClkEn),
    .ctlOut   (ctlOut),
    .ctlOe    (ctlOe),
    .dOut     (dOut),
    .dOe      (dOe),
    .initDone (initDone),
    .lreqValid(lreqValid)
  );

endmodule

// File: rtl/lis_checker.sv
module lis_checker
  import lis_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              lpsIn,
  input logic              lreqIn,
  input logic              sysClkEn,
  input logic [1:0]        ctlOut,
  input logic              ctlOe,
  input logic [DATA_W-1:0] dOut,
  input logic              dOe,
  input logic              initDone,
  input logic              lreqValid
);

  // R3
  clk_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sysClkEn |-> (!ctlOe && !dOe));

  // R2
  wake_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysClkEn) |-> $past(lpsIn, 2));

  // R4 R5: the first clocked cycle always drives low
  first_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysClkEn) |-> (ctlOe && dOe && ctlOut == 2'b00 && dOut == '0));

  // R6
  rx_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sysClkEn && ctlOut == CTL_RECEIVE) |-> (dOut == {DATA_W{1'b1}}));

  // R8
  idle_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (sysClkEn && ctlOe && dOe && ctlOut == 2'b00 && dOut == '0));

  // R8
  done_after_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> ($past(ctlOut) == CTL_RECEIVE));

  // R10
  lreq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    lreqValid |-> ($past(initDone) && $past(lreqIn)));

  // R11
  lps_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!lpsIn, 2) |-> (!initDone && !sysClkEn && !lreqValid));

endmodule

bind phy_link_init_seq lis_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .lpsIn    (lpsIn),
  .lreqIn   (lreqIn),
  .sysClkEn (sysClkEn),
  .ctlOut   (ctlOut),
  .ctlOe    (ctlOe),
  .dOut     (dOut),
  .dOe      (dOe),
  .initDone (initDone),
  .lreqValid(lreqValid)
);

// File: tb/tb_phy_link_init_seq.sv
module tb_phy_link_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam int MIN_OFF    = 6;
  localparam int LOW_DRIVE  = 7;
  localparam int RX_START   = 8;
  localparam int RX_CYCLES  = 2;
  localparam int DATA_W     = 8;
  localparam int DONE_K     = RX_START + RX_CYCLES;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lpsIn = 1'b0;
  logic isoIn = 1'b0;
  logic lreqIn = 1'b0;
  logic sysClkEn, ctlOe, dOe, initDone, lreqValid;
  logic [1:0] ctlOut;
  logic [DATA_W-1:0] dOut;

  phy_link_init_seq #(
    .MIN_OFF_CYCLES(MIN_OFF), .LOW_DRIVE_CYCLES(LOW_DRIVE),
    .RX_START(RX_START), .RX_CYCLES(RX_CYCLES), .DATA_W(DATA_W)
  ) dut (
    .clk(clk), .rstN(rstN), .lpsIn(lpsIn), .isoIn(isoIn), .lreqIn(lreqIn),
    .sysClkEn(sysClkEn), .ctlOut(ctlOut), .ctlOe(ctlOe), .dOut(dOut),
    .dOe(dOe), .initDone(initDone), .lreqValid(lreqValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  checks = 0;
  int  fails = 0;
  bit  cmpOn = 1'b0;
  bit  finished = 1'b0;

  // bench reference state
  int  mOffCnt = 0;
  int  mK = 0;
  bit  mIso = 1'b0;
  bit  mEverRan = 1'b0;
  logic eClk = 0, eCtlOe = 0, eDOe = 0, eDone = 0, eLreq = 0;
  logic [1:0] eCtl = 0;
  logic [DATA_W-1:0] eD = 0;
  string eTag = "R1";

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // expected visible outputs for the reference state k, mode iso
  task automatic setExp(input int k, input bit iso);
    eClk = 0; eCtlOe = 0; eDOe = 0; eDone = 0; eCtl = 2'b00; eD = '0;
    if (k == 0) begin
      eTag = mEverRan ? "R11" : "R1";
    end else if (k < RX_START) begin
      eClk = 1;
      eCtlOe = iso ? (k == 1) : (k <= LOW_DRIVE);
      eDOe = eCtlOe;
      eTag = iso ? "R4" : "R5";
    end else if (k < DONE_K) begin
      eClk = 1; eCtl = 2'b10; eD = '1;
      eCtlOe = iso ? 1'b1 : (k == RX_START);
      eDOe = eCtlOe;
      eTag = iso ? "R6" : "R7";
    end else begin
      eClk = 1; eCtlOe = 1; eDOe = 1; eDone = 1;
      eTag = "R8";
    end
  endtask

  always @(posedge clk) begin
    bit prevDone;
    if (!rstN) begin
      mOffCnt = 0; mK = 0;
      setExp(0, 1'b0);
      eLreq = 0;
    end else begin
      prevDone = eDone;
      eLreq = prevDone && (mK == DONE_K) && lreqIn;
      setExp(mK, mIso);
      if (mK > 0) begin
        if (!lpsIn) begin mK = 0; mOffCnt = 1; end
        else if (mK < DONE_K) mK++;
      end else if (lpsIn) begin
        if (mOffCnt == MIN_OFF) begin mK = 1; mIso = isoIn; mEverRan = 1; end
        mOffCnt = 0;
      end else if (mOffCnt < MIN_OFF) begin
        mOffCnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (cmpOn && !finished) begin
      check(sysClkEn === eClk, "R3", "sysClkEn", 32'(sysClkEn), 32'(eClk));
      check(ctlOe === eCtlOe, eTag, "ctlOe", 32'(ctlOe), 32'(eCtlOe));
      check(dOe === eDOe, eTag, "dOe", 32'(dOe), 32'(eDOe));
      check(ctlOut === eCtl, eTag, "ctlOut", 32'(ctlOut), 32'(eCtl));
      check(dOut === eD, eTag, "dOut", 32'(dOut), 32'(eD));
      check(initDone === eDone, eTag, "initDone", 32'(initDone), 32'(eDone));
      check(lreqValid === eLreq, "R10", "lreqValid", 32'(lreqValid), 32'(eLreq));
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog (any R) actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd24681));
    // R1: reset values
    waitCyc(3);
    check(!sysClkEn && !ctlOe && !dOe, "R1", "enables in reset", {sysClkEn, ctlOe, dOe}, 0);
    check(!initDone && !lreqValid, "R1", "flags in reset", {initDone, lreqValid}, 0);
    check(ctlOut == 0 && dOut == 0, "R1", "values in reset", {ctlOut, dOut}, 0);
    lpsIn = 1'b1;
    rstN = 1'b1;
    cmpOn = 1'b1;
    // R2: high straight out of reset starts nothing
    waitCyc(6);
    check(!sysClkEn, "R2", "no wake after reset", 32'(sysClkEn), 0);

    // R2: short low pulse rejected
    @(negedge clk); lpsIn = 1'b0;
    waitCyc(MIN_OFF - 1); lpsIn = 1'b1;
    waitCyc(12);
    check(!sysClkEn, "R2", "short low rejected", 32'(sysClkEn), 0);

    // shared-driver wake, exact minimum low time; strap flips mid-run (R9)
    lpsIn = 1'b0;
    waitCyc(MIN_OFF); lpsIn = 1'b1; isoIn = 1'b1; lreqIn = 1'b1;
    waitCyc(3); isoIn = 1'b0;
    waitCyc(2);
    check(sysClkEn && !ctlOe && !dOe, "R9", "mode kept after strap change",
          {sysClkEn, ctlOe, dOe}, 32'b100);
    waitCyc(12);
    check(initDone === 1'b1, "R8", "handoff reached", 32'(initDone), 1);
    check(lreqValid === 1'b1, "R10", "request forwarded", 32'(lreqValid), 1);

    // R11: drop returns to off
    lpsIn = 1'b0;
    waitCyc(2);
    check(!initDone && !sysClkEn, "R11", "drop clears", {initDone, sysClkEn}, 0);
    waitCyc(MIN_OFF);
    // separate-driver wake, dropped mid-sequence
    lpsIn = 1'b1; isoIn = 1'b0; lreqIn = 1'b0;
    waitCyc(5); lpsIn = 1'b0;
    waitCyc(2);
    check(!sysClkEn && !ctlOe, "R11", "mid-run drop", {sysClkEn, ctlOe}, 0);
    waitCyc(MIN_OFF + 2);
    // separate-driver full run
    lpsIn = 1'b1; isoIn = 1'b0;
    waitCyc(RX_START + 1);
    check(ctlOe && ctlOut == 2'b10 && dOut == '1, "R7", "first receive cycle driven",
          {ctlOe, ctlOut}, 32'b110);
    @(negedge clk);
    check(!ctlOe && !dOe, "R7", "later receive cycle released", {ctlOe, dOe}, 0);
    waitCyc(6);

    // random phase
    for (int seg = 0; seg < 150; seg++) begin
      int lowLen = $urandom_range(1, MIN_OFF + 3);
      int highLen = $urandom_range(1, 24);
      lpsIn = 1'b0;
      for (int i = 0; i < lowLen; i++) begin
        lreqIn = 1'($urandom % 2);
        @(negedge clk);
      end
      lpsIn = 1'b1;
      isoIn = 1'($urandom % 2);
      for (int i = 0; i < highLen; i++) begin
        lreqIn = 1'($urandom % 2);
        if ($urandom % 8 == 0) isoIn = ~isoIn;
        @(negedge clk);
      end
    end
    waitCyc(4);
    summary();
  end

endmodule